// File: doc/BRIEF.md
# Tag Check Fault Reporter

This block takes the outcome of a failed memory tag comparison and turns it into the response chosen by a 2-bit check-fault mode field. The mode is read from the system control word that accompanies each event. Where the field sits in that word depends on whether the translation regime is a user-level one. Three of the four mode values have an effect. Mode 1 produces a synchronous abort record that holds the faulting address and a syndrome. Mode 2 sets a sticky bit in a per-exception-level asynchronous fault status register. Mode 3 is reserved and produces a one-cycle diagnostic pulse. Mode 0 discards the event and has no effect.

Fail events arrive on a valid/ready stream. Abort records leave on a valid/ready stream. An abort record stays on the output, unchanged, until the consumer takes it. While a record waits, `fail_ready` is low and no new event of any mode is accepted, so events are handled strictly in arrival order. `fail_ready` goes high again in the cycle in which `abort_ready` is high, so an output that is being drained does not cost an idle cycle. Software clears status bits through a write-one-to-clear port.

Top module: `tcf_fault_reporter`

## Requirements
- R1: For user-level regimes (`fail_user`=1) the mode is `fail_ctrl[39:38]`. Otherwise it is `fail_ctrl[41:40]`. The other field has no effect.
- R2: An event accepted in mode 0 raises no abort, no diagnostic pulse and no status change.
- R3: An event accepted in mode 1 makes `abort_valid` high in the next cycle, with `abort_vaddr` equal to the event's `fail_vaddr`.
- R4: The abort syndrome is laid out as follows:
  - bits [31:26] are 0x25 when `fail_cur_el` is non-zero and 0x24 when it is zero;
  - bit 25 is 1;
  - bit 6 is `fail_write`;
  - bits [5:0] are 0x11;
  - all other bits are 0.
- R5: An event accepted in mode 2 raises no abort and no pulse. In the next cycle it sets bit `2*fail_tgt_el + sel` of `fault_status`.
- R6: `sel` is `fail_vaddr[55]` when `fail_two_ranges`=1, and 0 otherwise.
- R7: An event accepted in mode 3 makes `rsvd_pulse` high for exactly one cycle. It raises no abort and no status change.
- R8: Status bits are sticky and OR together across events. A cycle with `clr_en`=1 clears the bits of level `clr_el` selected by `clr_mask` (bit 0 of the mask is sel 0). If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: While `abort_valid`=1 and `abort_ready`=0, the abort record stays stable and `fail_ready` is 0. `fail_ready` = !`abort_valid` || `abort_ready`.
- R10: After reset, `fault_status` is 0, `abort_valid` is 0, `rsvd_pulse` is 0 and `fail_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_valid | input | 1 | A tag check failure event is offered |
| fail_ready | output | 1 | The block accepts the event this cycle |
| fail_vaddr | input | 64 | Faulting virtual address |
| fail_write | input | 1 | The failing access was a write |
| fail_user | input | 1 | The regime is user level |
| fail_two_ranges | input | 1 | The regime has two address ranges |
| fail_cur_el | input | 2 | Current exception level |
| fail_tgt_el | input | 2 | Exception level whose status register is updated |
| fail_ctrl | input | 64 | System control word that holds the mode fields |
| abort_valid | output | 1 | A synchronous abort record is present |
| abort_ready | input | 1 | The consumer takes the abort record |
| abort_vaddr | output | 64 | Fault address of the abort |
| abort_syndrome | output | 32 | Abort syndrome word |
| rsvd_pulse | output | 1 | One-cycle pulse when the reserved mode is used |
| clr_en | input | 1 | Status clear strobe |
| clr_el | input | 2 | Level whose status bits are cleared |
| clr_mask | input | 2 | Status bits to clear (write one to clear) |
| fault_status | output | 8 | Sticky status, two bits per level, level 0 lowest |

## Verification
A wrong mode selection shows up one cycle after acceptance as the wrong kind of response: an abort where a status bit was expected, or nothing where a pulse was expected. The control word always carries a different mode in the unused field, so selecting the wrong field cannot go unnoticed. A corrupted status register shows up on `fault_status` one cycle after the set or clear that touched it. A lost or overwritten abort record shows up while back-pressure holds the output, because the stalled record must keep its address and syndrome until the consumer takes it.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [1:0] {
    TCF_IGNORE = 2'd0,
    TCF_SYNC   = 2'd1,
    TCF_ASYNC  = 2'd2,
    TCF_RSVD   = 2'd3
  } tcf_mode_e;

  localparam int unsigned SYN_W = 32;
  localparam logic [5:0] EC_ABT_LOWER = 6'h24;
  localparam logic [5:0] EC_ABT_SAME  = 6'h25;
  localparam logic [5:0] FSC_TAG      = 6'h11;

  function automatic logic [SYN_W-1:0] tcf_syndrome(input logic cur_nz, input logic wr);
    logic [5:0] ec;
    ec = cur_nz ? EC_ABT_SAME : EC_ABT_LOWER;
    return {ec, 1'b1, 18'd0, wr, FSC_TAG};
  endfunction

endpackage

// File: rtl/tcf_mode_sel.sv
module tcf_mode_sel #(
  parameter int unsigned CTRL_W   = 64,
  parameter int unsigned USER_LSB = 38,
  parameter int unsigned PRIV_LSB = 40
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              user,
  output tcf_pkg::tcf_mode_e mode
);
  logic [1:0] user_field;
  logic [1:0] priv_field;
  logic       unused_ctrl;

  assign user_field  = ctrl[USER_LSB +: 2];
  assign priv_field  = ctrl[PRIV_LSB +: 2];
  assign unused_ctrl = ^ctrl;

  always_comb begin
    mode = tcf_pkg::tcf_mode_e'(user ? user_field : priv_field);
  end
endmodule

// File: rtl/tcf_abort_slot.sv
module tcf_abort_slot #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SYN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_vaddr,
  input  logic [SYN_W-1:0]  in_syn,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_vaddr,
  output logic [SYN_W-1:0]  out_syn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vaddr <= '0;
      out_syn   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_vaddr <= in_vaddr;
      out_syn   <= in_syn;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tcf_status_bank.sv
module tcf_status_bank #(
  parameter int unsigned NUM_EL = 4,
  localparam int unsigned EL_W  = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [EL_W-1:0]   set_el,
  input  logic              set_sel,
  input  logic              clr_en,
  input  logic [EL_W-1:0]   clr_el,
  input  logic [1:0]        clr_mask,
  output logic [2*NUM_EL-1:0] status
);
  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    for (genvar s = 0; s < 2; s++) begin : g_bit
      logic set_hit;
      logic clr_hit;
      assign set_hit = set_en && (set_el == EL_W'(e)) && (set_sel == 1'(s));
      assign clr_hit = clr_en && (clr_el == EL_W'(e)) && clr_mask[s];
      always_ff @(posedge clk) begin
        if (!rst_n)       status[2*e+s] <= 1'b0;
        else if (set_hit) status[2*e+s] <= 1'b1;
        else if (clr_hit) status[2*e+s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcf_fault_reporter.sv
module tcf_fault_reporter #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned CTRL_W    = 64,
  parameter int unsigned NUM_EL    = 4,
  parameter int unsigned USER_LSB  = 38,
  parameter int unsigned PRIV_LSB  = 40,
  parameter int unsigned RANGE_BIT = 55,
  localparam int unsigned EL_W     = (NUM_EL > 1) ? $clog2(NUM_EL) : 1,
  localparam int unsigned SYN_W    = tcf_pkg::SYN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fail_valid,
  output logic                fail_ready,
  input  logic [ADDR_W-1:0]   fail_vaddr,
  input  logic                fail_write,
  input  logic                fail_user,
  input  logic                fail_two_ranges,
  input  logic [EL_W-1:0]     fail_cur_el,
  input  logic [EL_W-1:0]     fail_tgt_el,
  input  logic [CTRL_W-1:0]   fail_ctrl,
  output logic                abort_valid,
  input  logic                abort_ready,
  output logic [ADDR_W-1:0]   abort_vaddr,
  output logic [SYN_W-1:0]    abort_syndrome,
  output logic                rsvd_pulse,
  input  logic                clr_en,
  input  logic [EL_W-1:0]     clr_el,
  input  logic [1:0]          clr_mask,
  output logic [2*NUM_EL-1:0] fault_status
);
  import tcf_pkg::*;

  tcf_mode_e        mode;
  logic             accept;
  logic             range_sel;
  logic [SYN_W-1:0] syn_next;

  tcf_mode_sel #(
    .CTRL_W(CTRL_W), .USER_LSB(USER_LSB), .PRIV_LSB(PRIV_LSB)
  ) u_mode (
    .ctrl(fail_ctrl), .user(fail_user), .mode(mode)
  );

  assign fail_ready = !abort_valid || abort_ready;
  assign accept     = fail_valid && fail_ready;
  assign range_sel  = fail_two_ranges && fail_vaddr[RANGE_BIT];
  assign syn_next   = tcf_syndrome(fail_cur_el != '0, fail_write);

  tcf_abort_slot #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(accept && (mode == TCF_SYNC)),
    .in_vaddr(fail_vaddr), .in_syn(syn_next),
    .out_ready(abort_ready), .out_valid(abort_valid),
    .out_vaddr(abort_vaddr), .out_syn(abort_syndrome)
  );

  tcf_status_bank #(.NUM_EL(NUM_EL)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept && (mode == TCF_ASYNC)),
    .set_el(fail_tgt_el), .set_sel(range_sel),
    .clr_en(clr_en), .clr_el(clr_el), .clr_mask(clr_mask),
    .status(fault_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rsvd_pulse <= 1'b0;
    else        rsvd_pulse <= accept && (mode == TCF_RSVD);
  end
endmodule

// File: rtl/tcf_fault_reporter_chk.sv
module tcf_fault_reporter_chk #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned CTRL_W   = 64,
  parameter int unsigned NUM_EL   = 4,
  parameter int unsigned USER_LSB = 38,
  parameter int unsigned PRIV_LSB = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fail_valid,
  input logic                fail_ready,
  input logic [ADDR_W-1:0]   fail_vaddr,
  input logic                fail_user,
  input logic [CTRL_W-1:0]   fail_ctrl,
  input logic                abort_valid,
  input logic                abort_ready,
  input logic [ADDR_W-1:0]   abort_vaddr,
  input logic [31:0]         abort_syndrome,
  input logic                rsvd_pulse,
  input logic                clr_en,
  input logic [2*NUM_EL-1:0] fault_status
);
  logic       acc;
  logic [1:0] mode_now;
  logic       unused_ctrl;

  assign acc         = fail_valid && fail_ready;
  assign mode_now    = fail_user ? fail_ctrl[USER_LSB +: 2] : fail_ctrl[PRIV_LSB +: 2];
  assign unused_ctrl = ^fail_ctrl;

  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_now == 2'd0 && !clr_en |=> !abort_valid && !rsvd_pulse && fault_status == $past(fault_status));

  assert_abort_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_now == 2'd1 |=> abort_valid && abort_vaddr == $past(fail_vaddr));

  assert_syndrome_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> abort_syndrome[5:0] == 6'h11 && abort_syndrome[25]);

  assert_async_no_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_now == 2'd2 |=> !abort_valid && !rsvd_pulse);

  assert_rsvd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode_now == 2'd3 |=> rsvd_pulse && !abort_valid);

  assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(fault_status) & ~fault_status)) |-> $past(clr_en));

  assert_abort_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid && !abort_ready |=> abort_valid && $stable(abort_vaddr) && $stable(abort_syndrome));
endmodule

bind tcf_fault_reporter tcf_fault_reporter_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .NUM_EL(NUM_EL),
  .USER_LSB(USER_LSB), .PRIV_LSB(PRIV_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_ready(fail_ready),
  .fail_vaddr(fail_vaddr), .fail_user(fail_user), .fail_ctrl(fail_ctrl),
  .abort_valid(abort_valid), .abort_ready(abort_ready), .abort_vaddr(abort_vaddr),
  .abort_syndrome(abort_syndrome), .rsvd_pulse(rsvd_pulse), .clr_en(clr_en),
  .fault_status(fault_status)
);

// File: tb/tcf_fault_reporter_tb.sv
`timescale 1ns/1ps
module tcf_fault_reporter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail_valid = 1'b0;
  logic        fail_ready;
  logic [63:0] fail_vaddr = '0;
  logic        fail_write = 1'b0;
  logic        fail_user = 1'b0;
  logic        fail_two_ranges = 1'b0;
  logic [1:0]  fail_cur_el = '0;
  logic [1:0]  fail_tgt_el = '0;
  logic [63:0] fail_ctrl = '0;
  logic        abort_valid;
  logic        abort_ready = 1'b0;
  logic [63:0] abort_vaddr;
  logic [31:0] abort_syndrome;
  logic        rsvd_pulse;
  logic        clr_en = 1'b0;
  logic [1:0]  clr_el = '0;
  logic [1:0]  clr_mask = '0;
  logic [7:0]  fault_status;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tcf_fault_reporter u_dut (.*);

  // vector: [11:10] mode [9:8] tgt [7:6] cur [5] wr [4] a55 [3] two [2] user
  function automatic logic [11:0] mkv(int m, int t, int c, int w, int a, int two, int u);
    return {2'(m), 2'(t), 2'(c), 1'(w), 1'(a), 1'(two), 1'(u), 2'b00};
  endfunction

  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    mkv(1,0,0,0,0,0,1), mkv(1,0,1,1,0,0,0), mkv(1,0,2,1,1,1,1), mkv(0,1,1,0,0,0,1),
    mkv(0,2,1,1,1,1,0), mkv(2,1,0,0,1,1,1), mkv(2,2,1,0,0,1,0), mkv(2,3,2,1,1,0,0),
    mkv(3,0,0,0,0,0,1), mkv(3,1,1,1,1,1,0), mkv(2,0,0,0,1,0,1), mkv(1,0,3,0,1,1,0)
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_syn(logic cur_nz, logic wr);
    logic [31:0] s;
    s = '0;
    s[31:26] = cur_nz ? 6'h25 : 6'h24;
    s[25] = 1'b1;
    s[6] = wr;
    s[5:0] = 6'h11;
    return s;
  endfunction

  // The unused field always carries the inverted mode, so a wrong field choice shows.
  task automatic drive(logic [1:0] m, logic [1:0] t, logic [1:0] c, logic w, logic a, logic two, logic u, logic [63:0] base);
    logic [63:0] ctl;
    ctl = 64'h5A00_0000_0000_0C3C;
    if (u) begin ctl[39:38] = m; ctl[41:40] = ~m; end
    else   begin ctl[41:40] = m; ctl[39:38] = ~m; end
    fail_ctrl = ctl; fail_user = u; fail_two_ranges = two;
    fail_cur_el = c; fail_tgt_el = t; fail_write = w;
    fail_vaddr = base | (a ? 64'h0080_0000_0000_0000 : 64'h0);
    fail_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 status", 64'(fault_status), 0);
    chk("R10 abort_valid", 64'(abort_valid), 0);
    chk("R10 rsvd", 64'(rsvd_pulse), 0);
    chk("R10 fail_ready", 64'(fail_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 status after release", 64'(fault_status), 0);

    // Table walk (R1..R7)
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      logic [1:0] m, t, c;
      logic w, a, two, u, sel;
      logic [63:0] base;
      v = VEC[i];
      m = v[11:10]; t = v[9:8]; c = v[7:6]; w = v[5]; a = v[4]; two = v[3]; u = v[2];
      base = 64'h0000_1234_0000_0000 | 64'(i << 4);
      sel = two & a;
      drive(m, t, c, w, a, two, u, base);
      @(negedge clk);
      fail_valid = 1'b0;
      chk("R1 R3 abort_valid by mode", 64'(abort_valid), 64'(m == 2'd1));
      if (m == 2'd1) begin
        chk("R3 abort_vaddr", abort_vaddr, fail_vaddr);
        chk("R4 syndrome", 64'(abort_syndrome), 64'(exp_syn(c != 2'd0, w)));
      end
      chk("R2 R5 R6 status", 64'(fault_status), (m == 2'd2) ? 64'(1) << (2*t + sel) : 64'd0);
      chk("R7 R2 rsvd_pulse", 64'(rsvd_pulse), 64'(m == 2'd3));
      abort_ready = 1'b1;
      clr_en = 1'b1; clr_el = t; clr_mask = 2'b11;
      @(negedge clk);
      if (m == 2'd3) chk("R7 pulse one cycle", 64'(rsvd_pulse), 0);
      chk("R9 abort drained", 64'(abort_valid), 0);
      chk("R8 cleared", 64'(fault_status), 0);
      abort_ready = 1'b0; clr_en = 1'b0;
    end

    // Back-pressure (R9)
    drive(2'd1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_00AA_0000_0010);
    @(negedge clk);
    chk("R9 first record", abort_vaddr, 64'h0000_00AA_0000_0010);
    drive(2'd1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0000_00BB_0000_0020);
    chk("R9 ready low while held", 64'(fail_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 record stable", abort_vaddr, 64'h0000_00AA_0000_0010);
    chk("R9 syndrome stable", 64'(abort_syndrome), 64'(exp_syn(1'b1, 1'b0)));
    abort_ready = 1'b1;
    #0.1;
    chk("R9 ready follows abort_ready", 64'(fail_ready), 1);
    @(negedge clk);
    fail_valid = 1'b0;
    chk("R9 second record loaded", abort_vaddr, 64'h0000_00BB_0000_0020);
    chk("R9 second valid", 64'(abort_valid), 1);
    chk("R4 second syndrome", 64'(abort_syndrome), 64'(exp_syn(1'b0, 1'b1)));
    @(negedge clk);
    abort_ready = 1'b0;
    chk("R9 drained", 64'(abort_valid), 0);

    // Sticky accumulate and set-over-clear (R8)
    drive(2'd2, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h100);
    @(negedge clk);
    chk("R8 first set", 64'(fault_status), 64'h04);
    drive(2'd2, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h200);
    clr_en = 1'b1; clr_el = 2'd1; clr_mask = 2'b11;
    @(negedge clk);
    fail_valid = 1'b0; clr_en = 1'b0;
    chk("R8 set wins over clear", 64'(fault_status), 64'h08);
    drive(2'd2, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h300);
    @(negedge clk);
    fail_valid = 1'b0;
    chk("R8 accumulate", 64'(fault_status), 64'h88);
    clr_en = 1'b1; clr_el = 2'd3; clr_mask = 2'b01;
    @(negedge clk);
    chk("R8 masked clear keeps bit", 64'(fault_status), 64'h88);
    clr_mask = 2'b10;
    @(negedge clk);
    clr_en = 1'b0;
    chk("R8 masked clear", 64'(fault_status), 64'h08);
    drive(2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h400);
    @(negedge clk);
    fail_valid = 1'b0;
    chk("R2 ignore keeps status", 64'(fault_status), 64'h08);
    chk("R2 ignore no abort", 64'(abort_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule